// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block holds the power control byte of a small 8-bit microcontroller and turns it into clock-enable and strobe-hold controls. Software writes the byte over a simple register bus. Setting the idle bit stops the CPU clock while timers, the serial port and the interrupt logic keep their clock. Setting the power-down bit stops every clock. If both bits are set, power-down wins. A new mode takes effect on the cycle after the write.

Idle ends when an enabled interrupt is pending: hardware clears the idle bit and the CPU clock comes back. Power-down has no clock to sample interrupts, so only a qualified external reset ends it. That reset must be held high for a set number of consecutive cycles. It clears the byte and reports a core reset for as long as it is held. While the block is idle, the address-latch and program-strobe pins are held high. In power-down they are held low.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After synchronous reset `rst`, the control byte reads 0x00, both clock enables are 1, `strb_hold` is 0 and `core_rst` is 0.
- R2: A read with `bus_rd` high returns the byte on `bus_rdata` one cycle later when `bus_addr` equals REG_ADDR (default 0x87), and 0x00 for any other address. Bits 6..4 always read 0 and are not stored.
- R3: A write to any address other than REG_ADDR leaves the control byte and the clock enables unchanged.
- R4: If bit 0 (idle) is written as 1 with bit 1 at 0, one cycle after the byte is updated: `cpu_clk_en`=0, `per_clk_en`=1, `strb_hold`=1, `strb_lvl`=1.
- R5: If bit 1 (power-down) is written as 1, whatever bit 0 holds, one cycle after the byte is updated: `cpu_clk_en`=0, `per_clk_en`=0, `strb_hold`=1, `strb_lvl`=0.
- R6: While the idle bit is set and power-down is clear, a cycle with `irq_pend` high (and no write to the byte) clears the idle bit. The other bits are kept, and `cpu_clk_en` returns to 1 one cycle later.
- R7: `irq_pend` has no effect on the byte when the idle bit is clear or when power-down is set.
- R8: While the power-down bit is set, bus writes to the byte are ignored.
- R9: Holding `ext_rst` high for RST_CYCLES consecutive cycles (default 24) clears the byte and drives `core_rst` high from that cycle for as long as `ext_rst` stays high. A shorter pulse, including one of RST_CYCLES-1 cycles, has no effect.
- R10: Bit 7 drives `baud_x2`. Bits 7, 3 and 2 are plain storage and do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_rst | input | 1 | External reset request, must be held to qualify |
| core_rst | output | 1 | Qualified reset to the rest of the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Timer/serial/interrupt clock enable |
| strb_hold | output | 1 | Force the ALE/program-strobe pins to a fixed level |
| strb_lvl | output | 1 | Level forced when `strb_hold` is 1 |
| baud_x2 | output | 1 | Serial baud doubling select |

## Verification
The assertions take for granted that the bus does not read and write the byte in the same cycle. They also assume `irq_pend` and `ext_rst` change only between clock edges. The timing checks reason about one register update followed by one output update, so they expect no overlapping write in the cycle that follows. The stimulus drives every input on the falling edge, and it issues bus reads and writes as separate single-cycle strobes. Reset pulses are chosen on both sides of the hold limit: a short pulse, exactly one cycle short, exactly long enough, and well beyond it.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CTL_W  = 8;
  localparam int B_IDL  = 0;
  localparam int B_PD   = 1;
  localparam int B_DBL  = 7;
  // bits kept in storage: 7, 3, 2, 1, 0
  localparam logic [CTL_W-1:0] CTL_KEEP = 8'h8F;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
  parameter int RST_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst,
  output logic rst_hit,
  output logic core_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CYCLES);
  localparam logic [CW-1:0] HIT = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;

  // the sample that completes the hold window qualifies the reset
  assign rst_hit = ext_rst && (cnt >= HIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      core_rst <= 1'b0;
    end else begin
      if (!ext_rst)
        cnt <= '0;
      else if (cnt != LIM)
        cnt <= cnt + 1'b1;
      core_rst <= rst_hit;
    end
  end
endmodule

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import pm_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  input  logic              wake,
  output logic [CTL_W-1:0]  bus_rdata,
  output logic              pd_q,
  output logic              idl_q,
  output logic              dbl_q
);
  logic [CTL_W-1:0] ctl_q;
  logic             sel;

  assign sel   = (bus_addr == REG_ADDR);
  assign pd_q  = ctl_q[B_PD];
  assign idl_q = ctl_q[B_IDL];
  assign dbl_q = ctl_q[B_DBL];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctl_q <= '0;
    end else if (pd_q) begin
      ctl_q <= ctl_q;                      // frozen until qualified reset
    end else if (bus_wr && sel) begin
      ctl_q <= bus_wdata & CTL_KEEP;
    end else if (idl_q && wake) begin
      ctl_q[B_IDL] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else
      bus_rdata <= (bus_rd && sel) ? ctl_q : '0;
  end
endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
  import pm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_q,
  input  logic idl_q,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic strb_hold,
  output logic strb_lvl
);
  pm_mode_e mode;

  always_comb begin
    if (pd_q)       mode = PM_DOWN;   // power-down has precedence
    else if (idl_q) mode = PM_IDLE;
    else            mode = PM_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      strb_hold  <= 1'b0;
      strb_lvl   <= 1'b0;
    end else begin
      unique case (mode)
        PM_DOWN: begin
          cpu_clk_en <= 1'b0; per_clk_en <= 1'b0;
          strb_hold  <= 1'b1; strb_lvl   <= 1'b0;
        end
        PM_IDLE: begin
          cpu_clk_en <= 1'b0; per_clk_en <= 1'b1;
          strb_hold  <= 1'b1; strb_lvl   <= 1'b1;
        end
        default: begin
          cpu_clk_en <= 1'b1; per_clk_en <= 1'b1;
          strb_hold  <= 1'b0; strb_lvl   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h87,
  parameter int                RST_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_pend,
  input  logic              ext_rst,
  output logic              core_rst,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              strb_hold,
  output logic              strb_lvl,
  output logic              baud_x2
);
  logic pd_q;
  logic idl_q;
  logic rst_hit;

  pm_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_rq (
    .clk      (clk),
    .rst      (rst),
    .ext_rst  (ext_rst),
    .rst_hit  (rst_hit),
    .core_rst (core_rst)
  );

  pm_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .clr       (rst_hit),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wake      (irq_pend),
    .bus_rdata (bus_rdata),
    .pd_q      (pd_q),
    .idl_q     (idl_q),
    .dbl_q     (baud_x2)
  );

  pm_clk_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .pd_q       (pd_q),
    .idl_q      (idl_q),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .strb_hold  (strb_hold),
    .strb_lvl   (strb_lvl)
  );
endmodule

// File: rtl/pm_chk.sv
module pm_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq_pend,
  input logic              ext_rst,
  input logic              core_rst,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              strb_hold,
  input logic              strb_lvl,
  input logic              pd_q,
  input logic              idl_q,
  input logic              rst_hit
);
  logic wr_hit;
  assign wr_hit = bus_wr && (bus_addr == REG_ADDR);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[6:4] == 3'b000);

  p_idle_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_wdata[1:0] == 2'b01 && !pd_q && !rst_hit)
    |=> ##1 (!cpu_clk_en && per_clk_en && strb_hold && strb_lvl));

  p_down_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && bus_wdata[1] && !rst_hit)
    |=> ##1 (!cpu_clk_en && !per_clk_en && strb_hold && !strb_lvl));

  p_gate_order_r5: assert property (@(posedge clk) disable iff (rst)
    !per_clk_en |-> !cpu_clk_en);

  p_irq_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (idl_q && !pd_q && irq_pend && !wr_hit && !rst_hit) |=> !idl_q);

  p_down_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (pd_q && !rst_hit) |=> pd_q);

  p_core_rst_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> $past(ext_rst));

  p_rst_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rst_hit |=> (!pd_q && !idl_q && core_rst));
endmodule

bind pwr_mode_ctl pm_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
  localparam int RSTC = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_pend = 1'b0, ext_rst = 1'b0;
  logic       core_rst, cpu_clk_en, per_clk_en, strb_hold, strb_lvl, baud_x2;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pwr_mode_ctl #(.ADDR_W(8), .REG_ADDR(8'h87), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
    .ext_rst(ext_rst), .core_rst(core_rst), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .strb_hold(strb_hold), .strb_lvl(strb_lvl),
    .baud_x2(baud_x2));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  logic [7:0] m_reg;
  int         m_cnt;
  bit         m_ok = 1'b0;
  bit e_cpu, e_per, e_hold, e_lvl, e_core;
  logic [7:0] e_rd;

  always @(posedge clk) begin
    bit hit, pd, idl;
    if (rst) begin
      m_reg = 8'h00; m_cnt = 0;
      e_cpu = 1; e_per = 1; e_hold = 0; e_lvl = 0; e_core = 0; e_rd = 8'h00;
    end else begin
      hit = ext_rst && (m_cnt >= RSTC - 1);
      m_cnt = ext_rst ? ((m_cnt < RSTC) ? m_cnt + 1 : m_cnt) : 0;
      pd  = m_reg[1];
      idl = m_reg[0];
      e_cpu  = !(pd || idl);
      e_per  = !pd;
      e_hold = pd || idl;
      e_lvl  = !pd && idl;
      e_rd   = (bus_rd && bus_addr == 8'h87) ? m_reg : 8'h00;
      e_core = hit;
      if (hit) m_reg = 8'h00;
      else if (pd) m_reg = m_reg;
      else if (bus_wr && bus_addr == 8'h87) m_reg = bus_wdata & 8'h8F;
      else if (idl && irq_pend) m_reg[0] = 1'b0;
    end
    m_ok = 1'b1;
  end

  always @(negedge clk) begin
    if (m_ok && !rst && !done) begin
      check("R4 R5 cpu_clk_en", int'(cpu_clk_en), int'(e_cpu));
      check("R5 per_clk_en",    int'(per_clk_en), int'(e_per));
      check("R4 R5 strb_hold",  int'(strb_hold),  int'(e_hold));
      check("R4 R5 strb_lvl",   int'(strb_lvl),   int'(e_lvl));
      check("R2 bus_rdata",     int'(bus_rdata),  int'(e_rd));
      check("R9 core_rst",      int'(core_rst),   int'(e_core));
      check("R10 baud_x2",      int'(baud_x2),    int'(m_reg[7]));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rst_pulse(input int n);
    @(negedge clk); ext_rst = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    ext_rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle_n(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cpu_clk_en", int'(cpu_clk_en), 1);
    check("R1 strb_hold", int'(strb_hold), 0);
    rd(8'h87, v); check("R1 ctl byte", int'(v), 8'h00);

    // R2 R10 storage and reserved bits
    wr(8'h87, 8'hFC); idle_n(1);
    rd(8'h87, v); check("R2 masked readback", int'(v), 8'h8C);
    check("R10 baud_x2 set", int'(baud_x2), 1);
    check("R10 flags keep run mode", int'(cpu_clk_en), 1);

    // R3 foreign address
    wr(8'h88, 8'h03); idle_n(2);
    rd(8'h87, v); check("R3 byte unchanged", int'(v), 8'h8C);
    check("R3 cpu still runs", int'(cpu_clk_en), 1);
    rd(8'h88, v); check("R2 foreign read zero", int'(v), 8'h00);

    // R4 idle
    wr(8'h87, 8'h0D); idle_n(1);
    check("R4 cpu gated", int'(cpu_clk_en), 0);
    check("R4 per running", int'(per_clk_en), 1);
    check("R4 strobes high", int'(strb_lvl), 1);

    // R6 interrupt wake
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    @(negedge clk);
    check("R6 cpu restarted", int'(cpu_clk_en), 1);
    rd(8'h87, v); check("R6 flags kept", int'(v), 8'h0C);

    // R7 interrupt in run mode
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    rd(8'h87, v); check("R7 run irq no effect", int'(v), 8'h0C);

    // R5 both bits: power-down wins
    wr(8'h87, 8'h03); idle_n(1);
    check("R5 per gated", int'(per_clk_en), 0);
    check("R5 strobes low", int'(strb_lvl), 0);
    @(negedge clk); irq_pend = 1'b1;
    idle_n(3); irq_pend = 1'b0;
    rd(8'h87, v); check("R7 irq ignored in down", int'(v), 8'h03);

    // R8 writes ignored while down
    wr(8'h87, 8'h00); idle_n(2);
    rd(8'h87, v); check("R8 write ignored", int'(v), 8'h03);
    check("R8 still down", int'(per_clk_en), 0);

    // R9 short pulses
    rst_pulse(10); idle_n(2);
    check("R9 short pulse", int'(per_clk_en), 0);
    rst_pulse(RSTC - 1); idle_n(2);
    check("R9 one short", int'(per_clk_en), 0);
    check("R9 no core reset", int'(core_rst), 0);
    // exact length
    rst_pulse(RSTC); idle_n(2);
    check("R9 exits down", int'(per_clk_en), 1);
    rd(8'h87, v); check("R9 byte cleared", int'(v), 8'h00);

    // long reset out of idle
    wr(8'h87, 8'h81); idle_n(1);
    check("R4 idle again", int'(cpu_clk_en), 0);
    @(negedge clk); ext_rst = 1'b1;
    idle_n(RSTC + 5);
    check("R9 core_rst held", int'(core_rst), 1);
    ext_rst = 1'b0; idle_n(2);
    check("R9 core_rst released", int'(core_rst), 0);
    check("R9 cpu back", int'(cpu_clk_en), 1);
    check("R10 baud cleared", int'(baud_x2), 0);

    idle_n(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule